// File: doc/BRIEF.md
# Mode-Switched Multiply-Accumulate Unit

This block is an unsigned 32x32 multiplier that sits beside a processor's register file. The processor reaches it through a register-transfer port. The port covers a small window of three 32-bit registers, numbered 25, 26 and 27. Register 25 holds control and status. Registers 26 and 27 expose the low and high words of the 64-bit result. The two operands arrive on two buses that mirror processor registers 28 and 29.

The block has two modes with different sampling triggers.

- **Multiply-only mode:** the operands are sampled on every instruction strobe. The plain 64-bit product appears in the result registers, and the hidden 64-bit accumulator is held at zero.
- **Accumulate mode:** the operands are sampled only when a write transfer starts at register 25. The product is added to the accumulator, and the 64-bit sum goes both to the result registers and back into the accumulator. A wrap of that addition sets a sticky carry flag.

Transfers are byte-granular. A transfer that falls outside the window raises an error flag and has no effect.

Top module: `mac_unit`

## Requirements
- R1: After reset the mode bit, the carry flag, the accumulator and both result words are zero, so a 12-byte read starting at register 25 lane 0 returns all zeros.
- R2: While the mode bit is 0, each cycle with `step` high and no write to register 25 loads op_a*op_b into the result registers (unsigned, 64-bit) and zeroes the accumulator. The result is visible from the next cycle.
- R3: While the mode bit is 1, `step` has no effect. Only a valid write transfer whose start register is 25 samples the operands.
- R4: On a valid write starting at register 25 whose resulting mode bit is 1, and that is not a clear, the accumulator plus op_a*op_b (modulo 2^64) is stored into both the accumulator and the result registers.
- R5: When the addition in R4 wraps past 2^64, the carry flag (register 25 bit 1) is set. It stays set through later accumulations until it is cleared.
- R6: A valid write covering byte 0 of register 25 with bit 1 set clears the carry flag and the accumulator. That cycle performs no accumulation and leaves the result registers unchanged; the mode bit takes bit 0 of the written byte.
- R7: A transfer whose start register is below 25, or whose start_reg*4 + lane + length exceeds 112, raises `xfer_err` in the same cycle. It reads as zero and changes no state.
- R8: Byte i of a transfer travels on data bits [8i+7:8i] and maps to window byte (start_reg*4 + lane + i - 100). Register 25 reads as mode in bit 0, carry in bit 1 and zero elsewhere. Register 26 returns the result low word and register 27 the result high word, and bytes at or beyond the length read as zero.
- R9: Writes to registers 26 and 27 are ignored.
- R10: The mode and carry bits change only when a write covers byte 0 of register 25. A valid write starting at register 25 at a higher lane still triggers R4 with the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Per-instruction strobe, multiply-only sampling |
| xfer_en | input | 1 | Transfer valid this cycle |
| xfer_wr | input | 1 | 1 = write into block, 0 = read |
| xfer_reg | input | 5 | Start register number |
| xfer_lane | input | 2 | Start byte lane within the start register |
| xfer_len | input | 7 | Transfer length in bytes |
| xfer_wdata | input | 96 | Write bytes, byte i at bits [8i+7:8i] |
| op_a | input | 32 | First operand bus (register 28) |
| op_b | input | 32 | Second operand bus (register 29) |
| xfer_rdata | output | 96 | Read bytes, byte i at bits [8i+7:8i] |
| xfer_err | output | 1 | Transfer out of the window |

## Verification
The bench builds the block with its defaults: a 32-bit word and a window based at register 25, which puts the bound at byte 112. At full 32-bit width, all-ones operands give the largest product, so two accumulations of it are enough to wrap the 64-bit accumulator and reach the carry. The bound can be approached exactly: a transfer ending at byte 112 is accepted and one ending at 113 is refused. A lane-2 read shows bytes from two result words stitched together.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W        = 32,
  parameter int BASE_REG = 25,
  parameter int REGW     = 5,
  parameter int LANEW    = 2,
  parameter int LENW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              xfer_en,
  input  logic              xfer_wr,
  input  logic [REGW-1:0]   xfer_reg,
  input  logic [LANEW-1:0]  xfer_lane,
  input  logic [LENW-1:0]   xfer_len,
  input  logic [3*W-1:0]    xfer_wdata,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic [3*W-1:0]    xfer_rdata,
  output logic              xfer_err
);
  localparam int BPW   = W / 8;
  localparam int NB    = 3 * BPW;
  localparam int PW    = 2 * W;
  localparam int LIMIT = (BASE_REG + 3) * BPW;
  localparam int IDXW  = $clog2(NB);

  logic          mode_q, carry_q;
  logic [PW-1:0] acc_q, prod_q;

  logic [15:0] span_end, start;
  logic        bad, ok, w25, cover0, clr, new_mode, wrap;
  logic [PW-1:0] mul, sum;

  assign span_end = 16'(xfer_reg) * 16'(BPW) + 16'(xfer_lane) + 16'(xfer_len);
  assign start    = 16'(xfer_reg) * 16'(BPW) + 16'(xfer_lane) - 16'(BASE_REG * BPW);
  assign bad      = (xfer_reg < REGW'(BASE_REG)) || (span_end > 16'(LIMIT));
  assign ok       = xfer_en && !bad;
  assign xfer_err = xfer_en && bad;

  assign w25      = ok && xfer_wr && (xfer_reg == REGW'(BASE_REG));
  assign cover0   = w25 && (xfer_lane == '0) && (xfer_len != '0);
  assign new_mode = cover0 ? xfer_wdata[0] : mode_q;
  assign clr      = cover0 && xfer_wdata[1];

  assign mul  = PW'(op_a) * PW'(op_b);
  assign sum  = acc_q + mul;
  assign wrap = sum < acc_q;

  logic [3*W-1:0] window;
  logic [7:0]     fb [NB];
  logic [IDXW-1:0] st;
  logic           rd_ok;

  assign window = {prod_q, {(W-2){1'b0}}, carry_q, mode_q};
  assign st     = start[IDXW-1:0];
  assign rd_ok  = ok && !xfer_wr;

  for (genvar j = 0; j < NB; j++) begin : g_fb
    assign fb[j] = window[8*j +: 8];
  end

  for (genvar i = 0; i < NB; i++) begin : g_rd
    logic [IDXW-1:0] idx;
    assign idx = st + IDXW'(i);
    assign xfer_rdata[8*i +: 8] =
      (rd_ok && (LENW'(i) < xfer_len)) ? fb[idx] : 8'h00;
  end

  logic unused_bits;
  assign unused_bits = ^{xfer_wdata[3*W-1:2], start[15:IDXW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
      acc_q   <= '0;
      prod_q  <= '0;
    end else if (clr) begin
      mode_q  <= new_mode;
      carry_q <= 1'b0;
      acc_q   <= '0;
    end else if (w25) begin
      mode_q <= new_mode;
      if (new_mode) begin
        prod_q <= sum;
        acc_q  <= sum;
        if (wrap) carry_q <= 1'b1;
      end else begin
        acc_q <= '0;
      end
    end else if (step && !mode_q) begin
      prod_q <= mul;
      acc_q  <= '0;
    end
  end
endmodule

module mac_unit_chk #(
  parameter int W = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          xfer_err,
  input logic [3*W-1:0] xfer_rdata,
  input logic          w25,
  input logic          clr,
  input logic          new_mode,
  input logic          mode,
  input logic          carry,
  input logic [2*W-1:0] acc,
  input logic [2*W-1:0] prod
);
  logic [2*W-1:0] ref_mul;
  assign ref_mul = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  // R2
  mul_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode && !w25) |=> (prod == $past(ref_mul)) && (acc == '0));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !w25) |=> $stable(prod));

  // R4
  acc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w25 && !clr && new_mode) |=> (acc == $past(acc) + $past(ref_mul)) && (prod == acc));

  // R5
  carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !clr) |=> carry);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !carry && (acc == '0) && $stable(prod));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> $stable(mode) && $stable(carry));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (xfer_rdata == '0));
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op_a(op_a), .op_b(op_b),
  .xfer_err(xfer_err), .xfer_rdata(xfer_rdata), .w25(w25), .clr(clr),
  .new_mode(new_mode), .mode(mode_q), .carry(carry_q), .acc(acc_q), .prod(prod_q)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, step = 0;
  logic        xfer_en = 0, xfer_wr = 0;
  logic [4:0]  xfer_reg = 0;
  logic [1:0]  xfer_lane = 0;
  logic [6:0]  xfer_len = 0;
  logic [95:0] xfer_wdata = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [95:0] xfer_rdata;
  logic        xfer_err;

  int n_chk = 0, n_bad = 0;

  mac_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [127:0] VEC [7] = '{
    {32'd3,        32'd5,        64'd15},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFE00000001},
    {32'h00010000, 32'h00010000, 64'h0000000100000000},
    {32'h80000000, 32'd2,        64'h0000000100000000},
    {32'hFFFFFFFF, 32'd1,        64'h00000000FFFFFFFF},
    {32'd0,        32'hDEADBEEF, 64'd0},
    {32'd7,        32'h20000000, 64'h00000000E0000000}
  };

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] r, input logic [1:0] l, input logic [6:0] n,
                    input logic [95:0] d);
    @(negedge clk);
    xfer_en = 1; xfer_wr = 1; xfer_reg = r; xfer_lane = l; xfer_len = n; xfer_wdata = d;
    @(negedge clk);
    xfer_en = 0; xfer_wr = 0;
  endtask

  task automatic rd(input logic [4:0] r, input logic [1:0] l, input logic [6:0] n,
                    output logic [95:0] d, output logic e);
    xfer_en = 1; xfer_wr = 0; xfer_reg = r; xfer_lane = l; xfer_len = n;
    #1;
    d = xfer_rdata; e = xfer_err;
    xfer_en = 0;
    #1;
  endtask

  task automatic pulse_step();
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
  endtask

  task automatic chk_prod(input string tag, input logic [63:0] exp);
    logic [95:0] d; logic e;
    rd(5'd26, 2'd0, 7'd8, d, e);
    chk(tag, d, {32'd0, exp});
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [95:0] d; logic e;
    rd(5'd25, 2'd0, 7'd4, d, e);
    chk(tag, d, {64'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [95:0] d; logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'd25, 2'd0, 7'd12, d, e);
    chk("R1 reset window", d, 96'd0);

    // R2 multiply-only vectors
    foreach (VEC[k]) begin
      op_a = VEC[k][127:96]; op_b = VEC[k][95:64];
      pulse_step();
      chk_prod($sformatf("R2 vec%0d", k), VEC[k][63:0]);
    end

    // R4 accumulate from zero
    op_a = 3; op_b = 4;
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R4 acc first", 64'd12);
    op_a = 5; op_b = 6;
    wr(5'd25, 2'd0, 7'd1, 96'hFD);
    chk_prod("R4 acc second", 64'd42);
    chk_stat("R8 status upper bits zero", 32'h1);

    // R3 step ignored in accumulate mode
    op_a = 9; op_b = 9;
    pulse_step(); pulse_step();
    chk_prod("R3 step ignored", 64'd42);

    // R9 writes to result registers ignored
    wr(5'd26, 2'd0, 7'd8, 96'h1111111111111111);
    chk_prod("R9 result write ignored", 64'd42);

    // R5 carry
    op_a = 32'hFFFFFFFF; op_b = 32'hFFFFFFFF;
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R4 big sum", 64'hFFFFFFFE0000002B);
    chk_stat("R5 no carry yet", 32'h1);
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R5 wrapped sum", 64'hFFFFFFFC0000002C);
    chk_stat("R5 carry set", 32'h3);
    op_a = 1; op_b = 1;
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R4 after wrap", 64'hFFFFFFFC0000002D);
    chk_stat("R5 carry sticky", 32'h3);

    // R8 partial read across words
    rd(5'd26, 2'd2, 7'd4, d, e);
    chk("R8 lane2 read", d, {64'd0, 32'hFFFC0000});

    // R7 errors
    @(negedge clk);
    xfer_en = 1; xfer_wr = 1; xfer_reg = 24; xfer_lane = 0; xfer_len = 1; xfer_wdata = 96'h03;
    #1 chk("R7 reg below window err", {95'd0, xfer_err}, 96'd1);
    @(negedge clk);
    xfer_en = 0;
    chk_stat("R7 no effect", 32'h3);
    rd(5'd27, 2'd1, 7'd4, d, e);
    chk("R7 over bound err", {95'd0, e}, 96'd1);
    chk("R7 err read zero", d, 96'd0);
    rd(5'd27, 2'd0, 7'd4, d, e);
    chk("R7 at bound ok", {95'd0, e}, 96'd0);
    chk("R8 reg27 high word", d, {64'd0, 32'hFFFFFFFC});

    // R10 write at higher lane triggers but keeps mode/carry
    wr(5'd25, 2'd1, 7'd1, 96'h02);
    chk_prod("R10 lane1 trigger", 64'hFFFFFFFC0000002E);
    chk_stat("R10 bits kept", 32'h3);

    // R6 clear
    op_a = 7; op_b = 7;
    wr(5'd25, 2'd0, 7'd1, 96'h03);
    chk_stat("R6 carry cleared", 32'h1);
    chk_prod("R6 result kept", 64'hFFFFFFFC0000002E);
    op_a = 2; op_b = 3;
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R6 acc zeroed", 64'd6);

    // R2 back to multiply-only, accumulator forced to zero
    wr(5'd25, 2'd0, 7'd1, 96'h00);
    chk_stat("R2 mode 0", 32'h0);
    op_a = 4; op_b = 5;
    pulse_step();
    chk_prod("R2 mult after switch", 64'd20);
    op_a = 1; op_b = 1;
    wr(5'd25, 2'd0, 7'd1, 96'h01);
    chk_prod("R2 acc was zero", 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule